// File: doc/BRIEF.md
# Linked-List DMA Descriptor Fetcher

This block walks chains of DMA block descriptors held in memory for up to a parameterised number of channels. Software or a neighbouring block starts a channel by giving it a channel number and the byte address of its first descriptor. A descriptor occupies seven consecutive 32-bit words. The fetcher reads the first five words into that channel's working registers with single reads, one at a time and in ascending address order. It then launches the block on a downstream data mover, passing the addresses, the transfer size and the decoded control fields.

When the mover reports completion, the fetcher writes back three words: the control-high word with its done flag set, and the source and destination status snapshots that the mover returned. It then either follows the next-descriptor pointer or ends the chain. One shared sequencer serves all channels. When it is idle it takes the lowest-numbered pending channel and runs that channel's whole chain before it looks at another channel.

Top module: `dfetch_top`

## Requirements
- R1: After reset, no memory request, no mover start and no event is asserted, and no channel is busy.
- R2: A descriptor is fetched as five reads at byte offsets 0, 4, 8, 12 and 16 from its pointer, in that order. Word 0 is the source address, word 1 the destination address, word 2 the next pointer, word 3 control-low and word 4 control-high. At most one read is outstanding, and a request holds its address and direction until it is accepted.
- R3: After the fetch, `mv_start` pulses for one cycle. The pulse carries the channel number, source, destination, size (control-high bits 11:0) and the raw control-low word. It also carries these decoded fields of control-low: flow type (bits 21:20), destination width (bits 3:1), source width (bits 6:4), destination address mode (bits 8:7) and source address mode (bits 10:9).
- R4: After `mv_done`, the block writes word 4 as control-high OR 0x1000 (bit 12 is the done flag), then word 5 with `mv_src_stat`, then word 6 with `mv_dst_stat`. Words 0 to 3 are never written.
- R5: If control-low bit 27 or bit 28 is set and the next pointer is non-zero, the next descriptor is fetched from that pointer on the same channel.
- R6: The chain ends when bits 27 and 28 are both clear or when the next pointer is zero. The channel then stops being busy, and `evt_xfer` pulses for that channel if bit 0 of the last descriptor's control-low is set.
- R7: After each descriptor's write-back, `evt_block` pulses for the channel if bit 0 of that descriptor's control-low is set.
- R8: A start pointer or a followed next pointer whose bits 1:0 are not zero raises a one-cycle `evt_err` for the channel, stops it, and starts no mover.
- R9: When the sequencer is idle it serves the lowest-numbered pending channel, and it finishes that chain before serving any other channel.
- R10: A start request for a channel that is already busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go_valid | input | 1 | Start request |
| go_chan | input | CW | Channel to start |
| go_ptr | input | 32 | Byte address of the first descriptor |
| chan_busy | output | NCH | Channel has a chain in progress |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| mv_start | output | 1 | Launch one block on the mover |
| mv_chan | output | CW | Channel of the launched block |
| mv_src | output | 32 | Source address |
| mv_dst | output | 32 | Destination address |
| mv_size | output | 12 | Block transfer size |
| mv_ctl | output | 32 | Raw control-low word |
| mv_flow | output | 2 | Flow type |
| mv_src_width | output | 3 | Source element width code |
| mv_dst_width | output | 3 | Destination element width code |
| mv_src_mode | output | 2 | Source address mode (0 inc, 1 dec, 2 fixed) |
| mv_dst_mode | output | 2 | Destination address mode |
| mv_done | input | 1 | Mover finished the block |
| mv_src_stat | input | 32 | Source status snapshot |
| mv_dst_stat | input | 32 | Destination status snapshot |
| evt_block | output | NCH | Block-complete pulse per channel |
| evt_xfer | output | NCH | Chain-complete pulse per channel |
| evt_err | output | NCH | Misaligned-pointer pulse per channel |

## Verification
The bench builds the block with NCH = 4. With four channels it can keep three channels pending behind a running chain, which exercises both the lowest-index-first pick and the rule that the running chain completes before another channel is served. The stimulus table covers both chaining bits, a null next pointer, chaining disabled with a non-zero pointer, and a misaligned next pointer. The bench also alternates between a memory that is always ready and one that stalls on every other cycle. The decoded flow, width and address-mode fields are taken from the mover start of each vector and compared with slices of the control word.

// File: rtl/dfetch_pkg.sv
package dfetch_pkg;

    localparam int DW = 32;
    localparam int SIZE_W = 12;

    // Word positions inside a descriptor (fetch and write-back order)
    localparam logic [2:0] W_SRC  = 3'd0;
    localparam logic [2:0] W_DST  = 3'd1;
    localparam logic [2:0] W_LLP  = 3'd2;
    localparam logic [2:0] W_CTLL = 3'd3;
    localparam logic [2:0] W_CTLH = 3'd4;
    localparam logic [2:0] W_SSTA = 3'd5;
    localparam logic [2:0] W_DSTA = 3'd6;

    // Control-low bit positions
    localparam int CL_INT_EN  = 0;
    localparam int CL_CHAIN_D = 27;
    localparam int CL_CHAIN_S = 28;
    // Control-high done flag
    localparam int CH_DONE = 12;

    typedef enum logic [2:0] {
        S_IDLE, S_CHECK, S_RD_REQ, S_RD_WAIT, S_LAUNCH, S_MOVE, S_WB_REQ, S_NEXT
    } seq_state_t;

    typedef enum logic [1:0] {AM_INC = 2'd0, AM_DEC = 2'd1, AM_FIX = 2'd2, AM_RSV = 2'd3} addr_mode_t;

    typedef struct packed {
        logic [DW-1:0] src;
        logic [DW-1:0] dst;
        logic [DW-1:0] llp;
        logic [DW-1:0] ctl_lo;
        logic [DW-1:0] ctl_hi;
    } desc_t;

    typedef struct packed {
        logic [1:0] flow;
        logic [2:0] src_width;
        logic [2:0] dst_width;
        addr_mode_t src_mode;
        addr_mode_t dst_mode;
    } mover_cmd_t;

    function automatic int ch_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic logic chain_req(input logic [DW-1:0] c);
        return c[CL_CHAIN_D] | c[CL_CHAIN_S];
    endfunction

    function automatic logic is_aligned(input logic [DW-1:0] p);
        return p[1:0] == 2'b00;
    endfunction

    function automatic logic [DW-1:0] mark_done(input logic [DW-1:0] h);
        return h | (DW'(1) << CH_DONE);
    endfunction

    function automatic mover_cmd_t decode_cmd(input logic [DW-1:0] c);
        mover_cmd_t m;
        m.flow      = c[21:20];
        m.dst_width = c[3:1];
        m.src_width = c[6:4];
        m.dst_mode  = addr_mode_t'(c[8:7]);
        m.src_mode  = addr_mode_t'(c[10:9]);
        return m;
    endfunction

endpackage

// File: rtl/dfetch_pick.sv
module dfetch_pick
    import dfetch_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic [NCH-1:0]             pend,
    output logic                       any,
    output logic [ch_bits(NCH)-1:0]    idx
);
    localparam int CW = ch_bits(NCH);

    always_comb begin
        any = |pend;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) idx = CW'(i);
        end
    end
endmodule

// File: rtl/dfetch_chregs.sv
module dfetch_chregs
    import dfetch_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       go_ld,
    input  logic [ch_bits(NCH)-1:0]    go_ch,
    input  logic [DW-1:0]              go_ptr,
    input  logic                       nx_ld,
    input  logic [ch_bits(NCH)-1:0]    nx_ch,
    input  logic [DW-1:0]              nx_ptr,
    input  logic                       wr_en,
    input  logic [ch_bits(NCH)-1:0]    wr_ch,
    input  logic [2:0]                 wr_idx,
    input  logic [DW-1:0]              wr_val,
    input  logic [ch_bits(NCH)-1:0]    sel_ch,
    output logic [DW-1:0]              sel_ptr,
    output desc_t                      sel_desc
);
    localparam int CW = ch_bits(NCH);

    logic [DW-1:0] ptr_q  [NCH];
    desc_t         desc_q [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                ptr_q[g] <= '0;
            end else if (nx_ld && nx_ch == CW'(g)) begin
                ptr_q[g] <= nx_ptr;
            end else if (go_ld && go_ch == CW'(g)) begin
                ptr_q[g] <= go_ptr;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                desc_q[g] <= '0;
            end else if (wr_en && wr_ch == CW'(g)) begin
                unique case (wr_idx)
                    W_SRC:   desc_q[g].src    <= wr_val;
                    W_DST:   desc_q[g].dst    <= wr_val;
                    W_LLP:   desc_q[g].llp    <= wr_val;
                    W_CTLL:  desc_q[g].ctl_lo <= wr_val;
                    W_CTLH:  desc_q[g].ctl_hi <= wr_val;
                    default: ;
                endcase
            end
        end
    end

    assign sel_ptr  = ptr_q[sel_ch];
    assign sel_desc = desc_q[sel_ch];
endmodule

// File: rtl/dfetch_seq.sv
module dfetch_seq
    import dfetch_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       pick_any,
    input  logic [ch_bits(NCH)-1:0]    pick_ch,
    input  logic [DW-1:0]              cur_ptr,
    input  logic [DW-1:0]              cur_llp,
    input  logic [DW-1:0]              cur_ctl_hi,
    input  logic                       chain_en,
    input  logic                       int_en,
    output logic [ch_bits(NCH)-1:0]    cur_ch,
    output logic                       nx_ld,
    output logic                       wr_en,
    output logic [2:0]                 wr_idx,
    output logic                       req_valid,
    output logic                       req_write,
    output logic [DW-1:0]              req_addr,
    output logic [DW-1:0]              req_wdata,
    input  logic                       req_ready,
    input  logic                       rsp_valid,
    output logic                       mv_start,
    input  logic                       mv_done,
    input  logic [DW-1:0]              mv_sstat,
    input  logic [DW-1:0]              mv_dstat,
    output logic                       ev_blk,
    output logic                       ev_xfer,
    output logic                       ev_err,
    output logic                       clr
);
    localparam int CW = ch_bits(NCH);

    seq_state_t        st_q, st_d;
    logic [CW-1:0]     ch_q, ch_d;
    logic [2:0]        idx_q, idx_d;
    logic [DW-1:0]     sst_q, dst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= S_IDLE;
            ch_q  <= '0;
            idx_q <= '0;
            sst_q <= '0;
            dst_q <= '0;
        end else begin
            st_q  <= st_d;
            ch_q  <= ch_d;
            idx_q <= idx_d;
            if (st_q == S_MOVE && mv_done) begin
                sst_q <= mv_sstat;
                dst_q <= mv_dstat;
            end
        end
    end

    assign cur_ch   = ch_q;
    assign wr_idx   = idx_q;
    assign req_addr = cur_ptr + {{(DW-5){1'b0}}, idx_q, 2'b00};

    always_comb begin
        st_d      = st_q;
        ch_d      = ch_q;
        idx_d     = idx_q;
        nx_ld     = 1'b0;
        wr_en     = 1'b0;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_wdata = '0;
        mv_start  = 1'b0;
        ev_blk    = 1'b0;
        ev_xfer   = 1'b0;
        ev_err    = 1'b0;
        clr       = 1'b0;
        unique case (st_q)
            S_IDLE: begin
                if (pick_any) begin
                    ch_d = pick_ch;
                    st_d = S_CHECK;
                end
            end
            S_CHECK: begin
                if (!is_aligned(cur_ptr)) begin
                    ev_err = 1'b1;
                    clr    = 1'b1;
                    st_d   = S_IDLE;
                end else begin
                    idx_d = W_SRC;
                    st_d  = S_RD_REQ;
                end
            end
            S_RD_REQ: begin
                req_valid = 1'b1;
                if (req_ready) st_d = S_RD_WAIT;
            end
            S_RD_WAIT: begin
                if (rsp_valid) begin
                    wr_en = 1'b1;
                    if (idx_q == W_CTLH) begin
                        st_d = S_LAUNCH;
                    end else begin
                        idx_d = idx_q + 3'd1;
                        st_d  = S_RD_REQ;
                    end
                end
            end
            S_LAUNCH: begin
                mv_start = 1'b1;
                st_d     = S_MOVE;
            end
            S_MOVE: begin
                if (mv_done) begin
                    idx_d = W_CTLH;
                    st_d  = S_WB_REQ;
                end
            end
            S_WB_REQ: begin
                req_valid = 1'b1;
                req_write = 1'b1;
                unique case (idx_q)
                    W_CTLH:  req_wdata = mark_done(cur_ctl_hi);
                    W_SSTA:  req_wdata = sst_q;
                    default: req_wdata = dst_q;
                endcase
                if (req_ready) begin
                    if (idx_q == W_DSTA) st_d = S_NEXT;
                    else idx_d = idx_q + 3'd1;
                end
            end
            S_NEXT: begin
                ev_blk = int_en;
                if (chain_en && cur_llp != '0) begin
                    if (!is_aligned(cur_llp)) begin
                        ev_err = 1'b1;
                        clr    = 1'b1;
                        st_d   = S_IDLE;
                    end else begin
                        nx_ld = 1'b1;
                        idx_d = W_SRC;
                        st_d  = S_RD_REQ;
                    end
                end else begin
                    ev_xfer = int_en;
                    clr     = 1'b1;
                    st_d    = S_IDLE;
                end
            end
            default: st_d = S_IDLE;
        endcase
    end
endmodule

// File: rtl/dfetch_top.sv
module dfetch_top
    import dfetch_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       go_valid,
    input  logic [ch_bits(NCH)-1:0]    go_chan,
    input  logic [31:0]                go_ptr,
    output logic [NCH-1:0]             chan_busy,
    output logic                       mem_req_valid,
    input  logic                       mem_req_ready,
    output logic                       mem_req_write,
    output logic [31:0]                mem_req_addr,
    output logic [31:0]                mem_req_wdata,
    input  logic                       mem_rsp_valid,
    input  logic [31:0]                mem_rsp_rdata,
    output logic                       mv_start,
    output logic [ch_bits(NCH)-1:0]    mv_chan,
    output logic [31:0]                mv_src,
    output logic [31:0]                mv_dst,
    output logic [11:0]                mv_size,
    output logic [31:0]                mv_ctl,
    output logic [1:0]                 mv_flow,
    output logic [2:0]                 mv_src_width,
    output logic [2:0]                 mv_dst_width,
    output logic [1:0]                 mv_src_mode,
    output logic [1:0]                 mv_dst_mode,
    input  logic                       mv_done,
    input  logic [31:0]                mv_src_stat,
    input  logic [31:0]                mv_dst_stat,
    output logic [NCH-1:0]             evt_block,
    output logic [NCH-1:0]             evt_xfer,
    output logic [NCH-1:0]             evt_err
);
    localparam int CW = ch_bits(NCH);

    logic [NCH-1:0] pend_q;
    logic           go_ok;
    logic           pick_any;
    logic [CW-1:0]  pick_ch;
    logic [CW-1:0]  cur_ch;
    logic           nx_ld, wr_en, clr;
    logic [2:0]     wr_idx;
    logic [DW-1:0]  cur_ptr;
    desc_t          cur_desc;
    mover_cmd_t     cmd;
    logic           ev_blk, ev_xfer, ev_err;

    assign go_ok = go_valid && !pend_q[go_chan];

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            if (go_ok) pend_q[go_chan] <= 1'b1;
            if (clr)   pend_q[cur_ch]  <= 1'b0;
        end
    end

    assign chan_busy = pend_q;

    dfetch_pick #(.NCH(NCH)) u_pick (
        .pend (pend_q),
        .any  (pick_any),
        .idx  (pick_ch)
    );

    dfetch_chregs #(.NCH(NCH)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .go_ld    (go_ok),
        .go_ch    (go_chan),
        .go_ptr   (go_ptr),
        .nx_ld    (nx_ld),
        .nx_ch    (cur_ch),
        .nx_ptr   (cur_desc.llp),
        .wr_en    (wr_en),
        .wr_ch    (cur_ch),
        .wr_idx   (wr_idx),
        .wr_val   (mem_rsp_rdata),
        .sel_ch   (cur_ch),
        .sel_ptr  (cur_ptr),
        .sel_desc (cur_desc)
    );

    dfetch_seq #(.NCH(NCH)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .pick_any   (pick_any),
        .pick_ch    (pick_ch),
        .cur_ptr    (cur_ptr),
        .cur_llp    (cur_desc.llp),
        .cur_ctl_hi (cur_desc.ctl_hi),
        .chain_en   (chain_req(cur_desc.ctl_lo)),
        .int_en     (cur_desc.ctl_lo[CL_INT_EN]),
        .cur_ch     (cur_ch),
        .nx_ld      (nx_ld),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .req_valid  (mem_req_valid),
        .req_write  (mem_req_write),
        .req_addr   (mem_req_addr),
        .req_wdata  (mem_req_wdata),
        .req_ready  (mem_req_ready),
        .rsp_valid  (mem_rsp_valid),
        .mv_start   (mv_start),
        .mv_done    (mv_done),
        .mv_sstat   (mv_src_stat),
        .mv_dstat   (mv_dst_stat),
        .ev_blk     (ev_blk),
        .ev_xfer    (ev_xfer),
        .ev_err     (ev_err),
        .clr        (clr)
    );

    assign cmd          = decode_cmd(cur_desc.ctl_lo);
    assign mv_chan      = cur_ch;
    assign mv_src       = cur_desc.src;
    assign mv_dst       = cur_desc.dst;
    assign mv_size      = cur_desc.ctl_hi[SIZE_W-1:0];
    assign mv_ctl       = cur_desc.ctl_lo;
    assign mv_flow      = cmd.flow;
    assign mv_src_width = cmd.src_width;
    assign mv_dst_width = cmd.dst_width;
    assign mv_src_mode  = cmd.src_mode;
    assign mv_dst_mode  = cmd.dst_mode;

    for (genvar g = 0; g < NCH; g++) begin : g_evt
        assign evt_block[g] = ev_blk  && (cur_ch == CW'(g));
        assign evt_xfer[g]  = ev_xfer && (cur_ch == CW'(g));
        assign evt_err[g]   = ev_err  && (cur_ch == CW'(g));
    end
endmodule

// File: rtl/dfetch_chk.sv
module dfetch_chk #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           mem_req_valid,
    input logic           mem_req_ready,
    input logic           mem_req_write,
    input logic [31:0]    mem_req_addr,
    input logic           mem_rsp_valid,
    input logic           mv_start,
    input logic           mv_done,
    input logic [NCH-1:0] evt_block,
    input logic [NCH-1:0] evt_xfer,
    input logic [NCH-1:0] evt_err
);
    logic rd_out_q;
    logic mv_out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_out_q <= 1'b0;
            mv_out_q <= 1'b0;
        end else begin
            if (mem_req_valid && mem_req_ready && !mem_req_write) rd_out_q <= 1'b1;
            else if (mem_rsp_valid) rd_out_q <= 1'b0;
            if (mv_start) mv_out_q <= 1'b1;
            else if (mv_done) mv_out_q <= 1'b0;
        end
    end

    a_r2_one_outstanding: assert property (@(posedge clk) disable iff (rst)
        rd_out_q |-> !mem_req_valid);

    a_r2_hold_request: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

    a_r3_start_pulse: assert property (@(posedge clk) disable iff (rst)
        mv_start |=> !mv_start);

    a_r4_quiet_while_moving: assert property (@(posedge clk) disable iff (rst)
        mv_out_q |-> (!mem_req_valid && !mv_start));

    a_r7_block_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(evt_block));

    a_r8_err_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(evt_err));

    a_r6_xfer_not_err: assert property (@(posedge clk) disable iff (rst)
        (evt_xfer & evt_err) == '0);
endmodule

bind dfetch_top dfetch_chk #(.NCH(NCH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mv_start      (mv_start),
    .mv_done       (mv_done),
    .evt_block     (evt_block),
    .evt_xfer      (evt_xfer),
    .evt_err       (evt_err)
);

// File: tb/sim_dfetch_top.sv
`timescale 1ns/1ps
module sim_dfetch_top;
    localparam int NCH = 4;
    localparam int CW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic go_valid = 1'b0;
    logic [CW-1:0] go_chan = '0;
    logic [31:0] go_ptr = '0;
    logic [NCH-1:0] chan_busy;
    logic mem_req_valid, mem_req_write;
    logic mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic mv_start;
    logic [CW-1:0] mv_chan;
    logic [31:0] mv_src, mv_dst, mv_ctl;
    logic [11:0] mv_size;
    logic [1:0] mv_flow, mv_src_mode, mv_dst_mode;
    logic [2:0] mv_src_width, mv_dst_width;
    logic mv_done = 1'b0;
    logic [31:0] mv_src_stat = '0, mv_dst_stat = '0;
    logic [NCH-1:0] evt_block, evt_xfer, evt_err;

    always #2.5 clk = ~clk;

    dfetch_top #(.NCH(NCH)) u0 (.*);

    int total = 0;
    int bad = 0;
    logic [31:0] mem [256];
    logic stall = 1'b0;

    // memory model: one-cycle read latency, optional ready stalls
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (rst) mem_req_ready <= 1'b1;
        else if (stall) mem_req_ready <= ~mem_req_ready;
        else mem_req_ready <= 1'b1;
        if (!rst && mem_req_valid && mem_req_ready) begin
            if (mem_req_write) mem[mem_req_addr[9:2]] <= mem_req_wdata;
            else begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= mem[mem_req_addr[9:2]];
            end
        end
    end

    // mover model: done four cycles after start
    int mv_cnt = 0;
    always @(posedge clk) begin
        mv_done <= 1'b0;
        if (rst) mv_cnt <= 0;
        else if (mv_start) begin
            mv_cnt <= 4;
            mv_src_stat <= mv_src ^ 32'h5A5A_0000;
            mv_dst_stat <= mv_dst ^ 32'h0000_A5A5;
        end else if (mv_cnt != 0) begin
            mv_cnt <= mv_cnt - 1;
            if (mv_cnt == 1) mv_done <= 1'b1;
        end
    end

    // monitors
    int n_start = 0;
    logic [31:0] lg_src [16];
    logic [31:0] lg_dst [16];
    logic [31:0] lg_ctl [16];
    logic [11:0] lg_size [16];
    logic [CW-1:0] lg_chan [16];
    logic [11:0] lg_fields [16];
    int c_blk [NCH];
    int c_xfer [NCH];
    int c_err [NCH];

    always @(negedge clk) begin
        if (!rst) begin
            if (mv_start && n_start < 16) begin
                lg_src[n_start]    = mv_src;
                lg_dst[n_start]    = mv_dst;
                lg_ctl[n_start]    = mv_ctl;
                lg_size[n_start]   = mv_size;
                lg_chan[n_start]   = mv_chan;
                lg_fields[n_start] = {mv_flow, mv_dst_width, mv_src_width, mv_dst_mode, mv_src_mode};
            end
            if (mv_start) n_start = n_start + 1;
            for (int i = 0; i < NCH; i++) begin
                if (evt_block[i]) c_blk[i] = c_blk[i] + 1;
                if (evt_xfer[i])  c_xfer[i] = c_xfer[i] + 1;
                if (evt_err[i])   c_err[i] = c_err[i] + 1;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic clear_logs();
        n_start = 0;
        for (int i = 0; i < NCH; i++) begin
            c_blk[i] = 0; c_xfer[i] = 0; c_err[i] = 0;
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 + i;
    endtask

    task automatic put_desc(input logic [31:0] p, input logic [31:0] s, input logic [31:0] d,
                            input logic [31:0] l, input logic [31:0] cl, input logic [31:0] ch);
        mem[p[9:2]]     = s;
        mem[p[9:2] + 1] = d;
        mem[p[9:2] + 2] = l;
        mem[p[9:2] + 3] = cl;
        mem[p[9:2] + 4] = ch;
        mem[p[9:2] + 5] = 32'h0;
        mem[p[9:2] + 6] = 32'h0;
    endtask

    task automatic go(input logic [CW-1:0] c, input logic [31:0] p);
        @(negedge clk);
        go_valid = 1'b1; go_chan = c; go_ptr = p;
        @(negedge clk);
        go_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        @(negedge clk);
        while (chan_busy != '0 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    // vector: {chan[3:0], start ptr, control-low of first descriptor, its next pointer}
    localparam logic [99:0] VEC [5] = '{
        {4'd0, 32'h0000_0100, 32'h0810_0315, 32'h0000_0200},
        {4'd1, 32'h0000_0140, 32'h1000_0000, 32'h0000_0240},
        {4'd2, 32'h0000_0180, 32'h0000_0001, 32'h0000_0280},
        {4'd3, 32'h0000_01C0, 32'h1820_0001, 32'h0000_0000},
        {4'd1, 32'h0000_0300, 32'h1000_0001, 32'h0000_0342}
    };

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear_mem();
        clear_logs();
        repeat (3) @(negedge clk);
        check("R1 busy in reset", {28'b0, chan_busy}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 no request", {31'b0, mem_req_valid}, 32'h0);
        check("R1 no mover start", {31'b0, mv_start}, 32'h0);
        check("R1 no events", {20'b0, evt_block, evt_xfer, evt_err}, 32'h0);
        check("R1 idle", {28'b0, chan_busy}, 32'h0);

        for (int v = 0; v < 5; v++) begin
            logic [3:0] ch;
            logic [31:0] p, cl, ll, s_a, d_a, h_a, s_b, d_b, h_b;
            logic chn, go2, errx;
            int eblk, exf;
            ch = VEC[v][99:96]; p = VEC[v][95:64]; cl = VEC[v][63:32]; ll = VEC[v][31:0];
            s_a = 32'hA000_0000 + v; d_a = 32'hD000_0000 + v; h_a = 32'h0003_0040 + v;
            s_b = 32'hB000_0000 + v; d_b = 32'hC000_0000 + v; h_b = 32'h0000_0080 + v;
            clear_mem();
            put_desc(p, s_a, d_a, ll, cl, h_a);
            if (ll != 0 && ll[1:0] == 2'b00) put_desc(ll, s_b, d_b, 32'h0000_03F0, 32'h1, h_b);
            clear_logs();
            stall = v[0];
            go(ch[CW-1:0], p);
            wait_idle();
            chn  = cl[27] | cl[28];
            go2  = chn && ll != 0 && ll[1:0] == 2'b00;
            errx = chn && ll != 0 && ll[1:0] != 2'b00;
            eblk = cl[0] + (go2 ? 1 : 0);
            exf  = errx ? 0 : (go2 ? 1 : cl[0]);
            check("R5 R6 R8 mover start count", n_start, go2 ? 2 : 1);
            check("R3 src", lg_src[0], s_a);
            check("R3 dst", lg_dst[0], d_a);
            check("R3 size", {20'b0, lg_size[0]}, {20'b0, h_a[11:0]});
            check("R3 chan", {30'b0, lg_chan[0]}, {28'b0, ch});
            check("R3 raw control", lg_ctl[0], cl);
            check("R3 decoded fields", {20'b0, lg_fields[0]},
                  {20'b0, cl[21:20], cl[3:1], cl[6:4], cl[8:7], cl[10:9]});
            check("R4 ctl-high done", mem[p[9:2] + 4], h_a | 32'h1000);
            check("R4 src stat", mem[p[9:2] + 5], s_a ^ 32'h5A5A_0000);
            check("R4 dst stat", mem[p[9:2] + 6], d_a ^ 32'h0000_A5A5);
            check("R4 word0 kept", mem[p[9:2]], s_a);
            check("R4 word2 kept", mem[p[9:2] + 2], ll);
            check("R4 word3 kept", mem[p[9:2] + 3], cl);
            if (go2) begin
                check("R5 second src", lg_src[1], s_b);
                check("R5 second size", {20'b0, lg_size[1]}, {20'b0, h_b[11:0]});
                check("R5 second done", mem[ll[9:2] + 4], h_b | 32'h1000);
            end
            check("R7 block events", c_blk[ch[CW-1:0]], eblk);
            check("R6 xfer events", c_xfer[ch[CW-1:0]], exf);
            check("R8 err events", c_err[ch[CW-1:0]], errx ? 1 : 0);
            check("R6 channel idle", {28'b0, chan_busy}, 32'h0);
        end

        // R8: misaligned start pointer
        stall = 1'b0;
        clear_mem();
        clear_logs();
        go(2'd2, 32'h0000_0102);
        wait_idle();
        check("R8 misaligned start no mover", n_start, 0);
        check("R8 misaligned start err", c_err[2], 1);
        check("R8 misaligned start no read", mem[8'h40], 32'hDEAD_0040);

        // R9 priority and R10 ignored start while busy
        clear_mem();
        clear_logs();
        put_desc(32'h100, 32'hA100, 32'hD100, 32'h200, 32'h0800_0001, 32'h10);
        put_desc(32'h200, 32'hB200, 32'hD200, 32'h0, 32'h1, 32'h20);
        put_desc(32'h140, 32'hA140, 32'hD140, 32'h0, 32'h1, 32'h30);
        put_desc(32'h1C0, 32'hA1C0, 32'hD1C0, 32'h0, 32'h1, 32'h40);
        go(2'd0, 32'h100);
        go(2'd3, 32'h1C0);
        go(2'd1, 32'h140);
        go(2'd0, 32'h1C0);
        wait_idle();
        check("R9 R10 start count", n_start, 4);
        check("R9 first chan", {30'b0, lg_chan[0]}, 32'd0);
        check("R9 chain kept chan", {30'b0, lg_chan[1]}, 32'd0);
        check("R10 chain src unchanged", lg_src[1], 32'hB200);
        check("R9 lowest pending next", {30'b0, lg_chan[2]}, 32'd1);
        check("R9 last chan", {30'b0, lg_chan[3]}, 32'd3);
        check("R10 ch0 xfer once", c_xfer[0], 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule